// File: doc/BRIEF.md
# Extended Processor State Save Sequencer

On a save command, this block writes selected parts of the processor's floating-point and vector state into a save area in memory. The save area starts at the address given with the command. The block covers two state components. The first is the x87 component: control, status, tag and opcode words, the instruction and data pointers, and eight 80-bit stack registers. The second is the SSE component: the MXCSR word, a fixed MXCSR mask value, and up to sixteen 128-bit vector registers. A component is saved only when the command's request mask and the enabled-feature register both select it.

The block writes to memory one 16-byte beat at a time, using a valid/ready handshake. Each beat carries a 16-bit byte-enable, so a beat shared by the two components changes only the bytes of the components that are selected. The save-area layout depends on the 64-bit-mode flag in two ways:

- The pointer fields take different forms.
- Vector registers 8 to 15 are written only in that mode.

When the command finishes, the block gives a one-cycle done pulse. If the save address is not 64-byte aligned, it gives a one-cycle fault pulse instead.

Top module: `state_save_seq`

## Requirements
- R1: A save command whose address has any of bits [5:0] set gives a one-cycle `fault` pulse in the cycle after the command. It issues no write beat, and the block returns to idle.
- R2: Mask bit 0 selects the x87 component and bit 1 selects the SSE component. A component is written only when its bit is set in both `req_mask` and `feat_en`.
- R3: The beat at offset 0 (x87 only) is laid out as follows, with all 16 bytes enabled:
  - bytes 0-1: control word
  - bytes 2-3: status word
  - byte 4: abridged tag
  - byte 5: zero
  - bytes 6-7: opcode
  - bytes 8-15 in 64-bit mode: the 64-bit instruction pointer
  - bytes 8-15 otherwise: instruction pointer [31:0] at byte 8, code selector at byte 12, zero at bytes 14-15
- R4: At offset 16, the x87 component fills bytes 16-23 with the data pointer. In 64-bit mode this is the 64-bit value. Otherwise it is pointer [31:0] at byte 16, the data selector at byte 20, and zero at bytes 22-23. These bytes are enabled by byte-enable bits [7:0].
- R5: At offset 16, the SSE component writes MXCSR at byte 24 and the MXCSR mask parameter at byte 28, enabled by bits [15:8]. When SSE is not selected, bits [15:8] are zero, so the MXCSR bytes are left untouched.
- R6: x87 register i (0-7) is written at offset 32+16·i. The beat holds the 64-bit fraction in bytes 0-7, the sign/exponent word in bytes 8-9 and zeros above, with all bytes enabled.
- R7: Vector register i is written at offset 160+16·i. Registers 8 to 15 are written only when `long_mode` was set at the command.
- R8: Beats go out in ascending address order, with one beat per accepted handshake. While `wr_ready` is low, the address, data and enables of the pending beat stay unchanged.
- R9: `done` pulses for exactly one cycle, in the cycle after the last beat is accepted. When no component is selected, it pulses in the cycle after the command and no beat is written.
- R10: No beat is written at offset 512 or above, so the header area is never changed.
- R11: A save command raised while a save is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Save command, one cycle |
| save_addr | input | ADDR_W | Base address of the save area |
| req_mask | input | 2 | Requested components (bit0 x87, bit1 SSE) |
| feat_en | input | 2 | Enabled-feature register (same bit map) |
| long_mode | input | 1 | 64-bit addressing mode flag |
| fcw | input | 16 | x87 control word |
| fsw | input | 16 | x87 status word |
| ftag | input | 8 | x87 abridged tag byte |
| fop | input | 16 | x87 last opcode |
| fip | input | 64 | x87 instruction pointer |
| fcs | input | 16 | x87 code selector |
| fdp | input | 64 | x87 data pointer |
| fds | input | 16 | x87 data selector |
| mxcsr | input | 32 | SSE control/status word |
| fpr | input | 8x80 | x87 stack registers, [63:0] fraction, [79:64] sign/exponent |
| vec | input | 16x128 | Vector registers |
| wr_ready | input | 1 | Memory accepts the current beat |
| wr_valid | output | 1 | Write beat valid |
| wr_addr | output | ADDR_W | Beat byte address |
| wr_data | output | 128 | Beat data, little-endian |
| wr_be | output | 16 | Byte enables |
| done | output | 1 | Save finished pulse |
| fault | output | 1 | Misalignment fault pulse |

## Verification
The hardest case to reach is the shared beat at offset 16. It mixes data from the two components, so its byte enables and its lower half depend jointly on both gating masks and on the mode. The bench reaches it by sweeping every combination of the two 2-bit masks in both modes. It computes each expected beat list arithmetically. It also throttles `wr_ready` in a rotating pattern, so held beats and back-to-back acceptances both occur. A command raised in the middle of a save checks that the save in progress continues unchanged.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
    localparam int FPR_N      = 8;
    localparam int VEC_N      = 16;
    localparam int VEC_LEGACY = 8;
    localparam int COMP_X87   = 0;
    localparam int COMP_SSE   = 1;

    localparam int SLOT_HDR  = 0;
    localparam int SLOT_PTR  = 1;
    localparam int SLOT_FPR0 = 2;
    localparam int SLOT_VEC0 = SLOT_FPR0 + FPR_N;
    localparam int NSLOT     = SLOT_VEC0 + VEC_N;
    localparam int SLOT_W    = $clog2(NSLOT);
    localparam int FPR_W     = $clog2(FPR_N);
    localparam int VEC_W     = $clog2(VEC_N);

    typedef logic [NSLOT-1:0] slot_vec_t;

    typedef enum logic {SQ_IDLE, SQ_RUN} sq_state_e;

    typedef struct packed {
        logic [127:0] data;
        logic [15:0]  be;
    } beat_t;

    typedef struct packed {
        logic              hit;
        logic [SLOT_W-1:0] idx;
    } pick_t;

    // lowest selected slot strictly above 'after'
    function automatic pick_t pick_after(slot_vec_t m, int after);
        pick_t p;
        p = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (m[i] && i > after) begin
                p.hit = 1'b1;
                p.idx = SLOT_W'(i);
            end
        end
        return p;
    endfunction
endpackage

// File: rtl/ssq_plan.sv
module ssq_plan
    import ssq_pkg::*;
(
    input  logic [1:0] req_mask,
    input  logic [1:0] feat_en,
    input  logic       long_mode,
    output slot_vec_t  plan
);
    logic x87_on;
    logic sse_on;

    assign x87_on = req_mask[COMP_X87] & feat_en[COMP_X87];
    assign sse_on = req_mask[COMP_SSE] & feat_en[COMP_SSE];

    assign plan[SLOT_HDR] = x87_on;
    assign plan[SLOT_PTR] = x87_on | sse_on;

    for (genvar gi = 0; gi < FPR_N; gi++) begin : g_fpr
        assign plan[SLOT_FPR0 + gi] = x87_on;
    end

    for (genvar gv = 0; gv < VEC_N; gv++) begin : g_vec
        if (gv < VEC_LEGACY) begin : g_low
            assign plan[SLOT_VEC0 + gv] = sse_on;
        end else begin : g_high
            assign plan[SLOT_VEC0 + gv] = sse_on & long_mode;
        end
    end
endmodule

// File: rtl/ssq_beat.sv
module ssq_beat
    import ssq_pkg::*;
#(
    parameter logic [31:0] MXCSR_MASK_VAL = 32'h0000_FFBF
) (
    input  logic [SLOT_W-1:0]          slot,
    input  logic                       long_mode,
    input  logic                       has_x87,
    input  logic                       has_sse,
    input  logic [15:0]                fcw,
    input  logic [15:0]                fsw,
    input  logic [7:0]                 ftag,
    input  logic [15:0]                fop,
    input  logic [63:0]                fip,
    input  logic [15:0]                fcs,
    input  logic [63:0]                fdp,
    input  logic [15:0]                fds,
    input  logic [31:0]                mxcsr,
    input  logic [FPR_N-1:0][79:0]     fpr,
    input  logic [VEC_N-1:0][127:0]    vec,
    output beat_t                      beat
);
    logic [FPR_W-1:0] fpr_sel;
    logic [VEC_W-1:0] vec_sel;

    assign fpr_sel = FPR_W'(slot - SLOT_W'(SLOT_FPR0));
    assign vec_sel = VEC_W'(slot - SLOT_W'(SLOT_VEC0));

    always_comb begin
        beat = '0;
        if (slot == SLOT_W'(SLOT_HDR)) begin
            beat.data[15:0]  = fcw;
            beat.data[31:16] = fsw;
            beat.data[39:32] = ftag;
            beat.data[63:48] = fop;
            if (long_mode) begin
                beat.data[127:64] = fip;
            end else begin
                beat.data[95:64]  = fip[31:0];
                beat.data[111:96] = fcs;
            end
            beat.be = '1;
        end else if (slot == SLOT_W'(SLOT_PTR)) begin
            if (has_x87) begin
                if (long_mode) begin
                    beat.data[63:0] = fdp;
                end else begin
                    beat.data[31:0]  = fdp[31:0];
                    beat.data[47:32] = fds;
                end
                beat.be[7:0] = '1;
            end
            if (has_sse) begin
                beat.data[95:64]  = mxcsr;
                beat.data[127:96] = MXCSR_MASK_VAL;
                beat.be[15:8]     = '1;
            end
        end else if (slot < SLOT_W'(SLOT_VEC0)) begin
            beat.data[79:0] = fpr[fpr_sel];
            beat.be         = '1;
        end else begin
            beat.data = vec[vec_sel];
            beat.be   = '1;
        end
    end
endmodule

// File: rtl/ssq_ctrl.sv
module ssq_ctrl
    import ssq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    input  slot_vec_t         plan,
    input  logic              long_mode,
    input  logic              wr_ready,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [SLOT_W-1:0] slot,
    output slot_vec_t         plan_q,
    output logic              mode_q,
    output logic              done,
    output logic              fault
);
    localparam int ALIGN_B = 6;
    localparam int BEAT_B  = 4;

    sq_state_e         st;
    logic [ADDR_W-1:0] base_q;
    logic [SLOT_W-1:0] slot_q;
    pick_t             first_p;
    pick_t             next_p;
    logic              misal;

    assign misal   = |addr[ALIGN_B-1:0];
    assign first_p = pick_after(plan, -1);
    assign next_p  = pick_after(plan_q, int'(slot_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= SQ_IDLE;
            base_q <= '0;
            slot_q <= '0;
            plan_q <= '0;
            mode_q <= 1'b0;
            done   <= 1'b0;
            fault  <= 1'b0;
        end else begin
            done  <= 1'b0;
            fault <= 1'b0;
            case (st)
                SQ_IDLE: begin
                    if (start) begin
                        if (misal) begin
                            fault <= 1'b1;
                        end else if (!first_p.hit) begin
                            done <= 1'b1;
                        end else begin
                            st     <= SQ_RUN;
                            base_q <= addr;
                            slot_q <= first_p.idx;
                            plan_q <= plan;
                            mode_q <= long_mode;
                        end
                    end
                end
                SQ_RUN: begin
                    if (wr_ready) begin
                        if (next_p.hit) begin
                            slot_q <= next_p.idx;
                        end else begin
                            st   <= SQ_IDLE;
                            done <= 1'b1;
                        end
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    assign wr_valid = (st == SQ_RUN);
    assign wr_addr  = base_q + (ADDR_W'(slot_q) << BEAT_B);
    assign slot     = slot_q;

    p_misalign_fault_r1: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_IDLE && start && misal) |=> (fault && !wr_valid));
    p_single_outcome_r9: assert property (@(posedge clk) disable iff (rst)
        !(done && fault));
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_hold_beat_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr)));
    p_ascend_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready) |=> (done || wr_addr > $past(wr_addr)));
    p_start_ignored_r11: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && start && !wr_ready) |=> (wr_valid && !fault));
endmodule

// File: rtl/state_save_seq.sv
module state_save_seq
    import ssq_pkg::*;
#(
    parameter int          ADDR_W         = 32,
    parameter logic [31:0] MXCSR_MASK_VAL = 32'h0000_FFBF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [ADDR_W-1:0]       save_addr,
    input  logic [1:0]              req_mask,
    input  logic [1:0]              feat_en,
    input  logic                    long_mode,
    input  logic [15:0]             fcw,
    input  logic [15:0]             fsw,
    input  logic [7:0]              ftag,
    input  logic [15:0]             fop,
    input  logic [63:0]             fip,
    input  logic [15:0]             fcs,
    input  logic [63:0]             fdp,
    input  logic [15:0]             fds,
    input  logic [31:0]             mxcsr,
    input  logic [FPR_N-1:0][79:0]  fpr,
    input  logic [VEC_N-1:0][127:0] vec,
    input  logic                    wr_ready,
    output logic                    wr_valid,
    output logic [ADDR_W-1:0]       wr_addr,
    output logic [127:0]            wr_data,
    output logic [15:0]             wr_be,
    output logic                    done,
    output logic                    fault
);
    slot_vec_t         plan;
    slot_vec_t         plan_q;
    logic              mode_q;
    logic [SLOT_W-1:0] slot;
    beat_t             beat;

    ssq_plan u_plan (
        .req_mask  (req_mask),
        .feat_en   (feat_en),
        .long_mode (long_mode),
        .plan      (plan)
    );

    ssq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .addr      (save_addr),
        .plan      (plan),
        .long_mode (long_mode),
        .wr_ready  (wr_ready),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .slot      (slot),
        .plan_q    (plan_q),
        .mode_q    (mode_q),
        .done      (done),
        .fault     (fault)
    );

    ssq_beat #(.MXCSR_MASK_VAL(MXCSR_MASK_VAL)) u_beat (
        .slot      (slot),
        .long_mode (mode_q),
        .has_x87   (plan_q[SLOT_HDR]),
        .has_sse   (plan_q[SLOT_VEC0]),
        .fcw       (fcw),
        .fsw       (fsw),
        .ftag      (ftag),
        .fop       (fop),
        .fip       (fip),
        .fcs       (fcs),
        .fdp       (fdp),
        .fds       (fds),
        .mxcsr     (mxcsr),
        .fpr       (fpr),
        .vec       (vec),
        .beat      (beat)
    );

    assign wr_data = beat.data;
    assign wr_be   = beat.be;

    p_vec_legacy_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !mode_q) |-> (slot < SLOT_W'(SLOT_VEC0 + VEC_LEGACY)));
    p_mxcsr_keep_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && slot == SLOT_W'(SLOT_PTR) && !plan_q[SLOT_VEC0]) |-> (wr_be[15:8] == 8'h00));
    p_x87_gated_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && slot != SLOT_W'(SLOT_PTR) && slot < SLOT_W'(SLOT_VEC0)) |-> plan_q[SLOT_HDR]);
endmodule

// File: tb/state_save_seq_bench.sv
module state_save_seq_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic               start = 1'b0;
    logic [31:0]        save_addr = '0;
    logic [1:0]         req_mask = '0;
    logic [1:0]         feat_en = '0;
    logic               long_mode = 1'b0;
    logic [15:0]        fcw = 16'h037F;
    logic [15:0]        fsw = 16'h3800;
    logic [7:0]         ftag = 8'hA5;
    logic [15:0]        fop = 16'h07DB;
    logic [63:0]        fip = 64'h1122_3344_5566_7788;
    logic [15:0]        fcs = 16'h0023;
    logic [63:0]        fdp = 64'h99AA_BBCC_DDEE_FF01;
    logic [15:0]        fds = 16'h002B;
    logic [31:0]        mxcsr = 32'h0000_1F80;
    logic [7:0][79:0]   fpr;
    logic [15:0][127:0] vec;
    logic               wr_ready = 1'b0;
    logic               wr_valid;
    logic [31:0]        wr_addr;
    logic [127:0]       wr_data;
    logic [15:0]        wr_be;
    logic               done;
    logic               fault;

    localparam logic [31:0] MASK_C = 32'h0000_FFBF;

    state_save_seq u_state_save_seq (
        .clk(clk), .rst(rst), .start(start), .save_addr(save_addr),
        .req_mask(req_mask), .feat_en(feat_en), .long_mode(long_mode),
        .fcw(fcw), .fsw(fsw), .ftag(ftag), .fop(fop), .fip(fip), .fcs(fcs),
        .fdp(fdp), .fds(fds), .mxcsr(mxcsr), .fpr(fpr), .vec(vec),
        .wr_ready(wr_ready), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_be(wr_be), .done(done), .fault(fault)
    );

    int checks = 0;
    int errors = 0;

    int           exp_off  [0:31];
    logic [127:0] exp_data [0:31];
    logic [15:0]  exp_be   [0:31];
    string        exp_tag  [0:31];
    int           exp_n;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [159:0] act, input logic [159:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic build(input logic [1:0] en, input logic [1:0] req, input logic lm);
        bit x87 = en[0] & req[0];
        bit sse = en[1] & req[1];
        logic [127:0] d;
        exp_n = 0;
        if (x87) begin
            d = '0;
            d[15:0] = fcw; d[31:16] = fsw; d[39:32] = ftag; d[63:48] = fop;
            if (lm) d[127:64] = fip;
            else begin d[95:64] = fip[31:0]; d[111:96] = fcs; end
            exp_off[exp_n] = 0; exp_data[exp_n] = d; exp_be[exp_n] = 16'hFFFF;
            exp_tag[exp_n] = "R3"; exp_n++;
        end
        if (x87 || sse) begin
            d = '0; exp_be[exp_n] = 16'h0000;
            if (x87) begin
                if (lm) d[63:0] = fdp;
                else begin d[31:0] = fdp[31:0]; d[47:32] = fds; end
                exp_be[exp_n][7:0] = 8'hFF;
            end
            if (sse) begin
                d[95:64] = mxcsr; d[127:96] = MASK_C;
                exp_be[exp_n][15:8] = 8'hFF;
            end
            exp_off[exp_n] = 16; exp_data[exp_n] = d;
            exp_tag[exp_n] = "R4 R5"; exp_n++;
        end
        if (x87) begin
            for (int i = 0; i < 8; i++) begin
                exp_off[exp_n] = 32 + 16 * i;
                exp_data[exp_n] = {48'h0, fpr[i]};
                exp_be[exp_n] = 16'hFFFF; exp_tag[exp_n] = "R6"; exp_n++;
            end
        end
        if (sse) begin
            for (int i = 0; i < 16; i++) begin
                if (i < 8 || lm) begin
                    exp_off[exp_n] = 160 + 16 * i;
                    exp_data[exp_n] = vec[i];
                    exp_be[exp_n] = 16'hFFFF; exp_tag[exp_n] = "R7"; exp_n++;
                end
            end
        end
    endtask

    task automatic run_case(input logic [1:0] en, input logic [1:0] req,
                            input logic lm, input logic [31:0] a, input bit poke);
        int  idx = 0;
        bit  fin = 0;
        bit  poked = 0;
        int  maxoff = 0;
        bit  r;
        build(en, req, lm);
        @(negedge clk);
        feat_en = en; req_mask = req; long_mode = lm; save_addr = a; start = 1'b1;
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            start = 1'b0;
            r = ((c + int'(a[12:10])) % 3) != 2;
            wr_ready = r;
            if (poke && idx == 3 && !poked) begin
                start = 1'b1; save_addr = a | 32'h5; long_mode = 1'b0; poked = 1;
            end
            #1;
            if (idx == exp_n) begin
                chk(done && !fault && !wr_valid, "R9", "done after last beat",
                    {157'h0, done, fault, wr_valid}, {157'h0, 3'b100});
                chk(maxoff < 512, "R10", "header untouched", 160'(maxoff), 160'(511));
                fin = 1;
                break;
            end
            chk(!done && !fault && wr_valid, "R8", "valid held during save",
                {157'h0, done, fault, wr_valid}, {157'h0, 3'b001});
            if (r && wr_valid) begin
                if (int'(wr_addr - a) > maxoff) maxoff = int'(wr_addr - a);
                chk(wr_addr == a + 32'(exp_off[idx]) && wr_data == exp_data[idx] && wr_be == exp_be[idx],
                    poked ? "R11" : exp_tag[idx], "beat addr/be/data",
                    {wr_addr[15:0], wr_be, wr_data}, {a[15:0] + 16'(exp_off[idx]), exp_be[idx], exp_data[idx]});
                idx++;
            end
        end
        if (!fin) chk(0, "R2", "beat count", 160'(idx), 160'(exp_n));
        @(negedge clk);
        start = 1'b0; wr_ready = 1'b0;
        #1;
        chk(!done && !fault, "R9", "done is one cycle", {158'h0, done, fault}, 160'h0);
    endtask

    task automatic run_misaligned(input logic [31:0] a);
        @(negedge clk);
        feat_en = 2'b11; req_mask = 2'b11; long_mode = 1'b1; save_addr = a; start = 1'b1;
        wr_ready = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #1;
        chk(fault && !done && !wr_valid, "R1", "fault pulse, no write",
            {157'h0, fault, done, wr_valid}, {157'h0, 3'b100});
        @(negedge clk);
        #1;
        chk(!fault && !wr_valid, "R1", "back to idle", {158'h0, fault, wr_valid}, 160'h0);
    endtask

    initial begin
        for (int i = 0; i < 8; i++)
            fpr[i] = {16'(16'hC000 + i), 64'hA5A5_0000_0000_0000 | 64'(i * 7 + 1)};
        for (int i = 0; i < 16; i++)
            vec[i] = {32'(i), 32'hDEAD_BEEF ^ 32'(i), 32'h0BAD_F00D + 32'(i), 32'h5A00_0000 | 32'(i)};
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(!done && !fault && !wr_valid, "R9", "reset state",
            {157'h0, done, fault, wr_valid}, 160'h0);
        // R2 R3 R4 R5 R6 R7: full sweep of gating masks in both modes
        for (int m = 0; m < 2; m++)
            for (int e = 0; e < 4; e++)
                for (int q = 0; q < 4; q++)
                    run_case(2'(e), 2'(q), m[0], 32'h0001_0000 + 32'((m * 16 + e * 4 + q) << 10), 0);
        // R1: misaligned bases
        run_misaligned(32'h0002_0001);
        run_misaligned(32'h0002_0008);
        run_misaligned(32'h0002_0010);
        run_misaligned(32'h0002_0020);
        run_misaligned(32'h0002_003F);
        // R11: command during an active save
        run_case(2'b11, 2'b11, 1'b1, 32'h0003_0040, 1);
        run_case(2'b11, 2'b11, 1'b0, 32'h0004_0FC0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule